// File: doc/BRIEF.md
# Dual Down-Counter Timer

A bus slave holding two identical down-counting timers behind one register bank. Software programs each timer through a small register window on a simple APB-style bus. It can load a start value, program a reload value that applies only at the next wrap, and choose a counting mode: periodic reload, free-running wrap to all ones, or one-shot stop at zero. It also picks a prescale ratio of 1, 16 or 256 and selects a 16-bit or 32-bit counter. In 16-bit mode only the low half of the counter moves, while the upper half keeps the value software last wrote.

Each timer raises a raw interrupt when its counter steps from one to zero. Software reads the raw and masked status and clears the raw status by writing to a clear register. Each timer drives its own interrupt line, and a combined line reports either one. Each timer is controlled by a three-state machine. IDLE goes to RUN once the enable bit reads set. RUN goes back to IDLE when the enable bit is cleared. RUN goes to HALT when a one-shot count reaches zero. HALT goes back to RUN on a LOAD write while enabled. HALT goes to IDLE when the enable bit is cleared.

Top module: `dual_timer`

## Requirements
- R1: After reset every timer reads LOAD 0, VALUE 0xFFFFFFFF, CONTROL 0, raw status 0, and all interrupt outputs are low.
- R2: Timer 0 sits at byte offset 0x00 and timer 1 at 0x20. Within a timer the registers are: 0x00 LOAD (read/write), 0x04 VALUE (read-only, writes ignored), 0x08 CONTROL (read/write, bits 7:0), 0x0C CLEAR (write-only, reads 0), 0x10 RAW (bit 0), 0x14 MASKED (bit 0) and 0x18 BGLOAD (read/write, reads the same reload value as LOAD). Addresses from 0x40 upward read 0 and ignore writes.
- R3: A LOAD write sets both the reload value and the counter in the same clock edge.
- R4: A BGLOAD write changes only the reload value; the counter keeps its value.
- R5: CONTROL bit 6 set, with bit 0 clear, selects periodic mode. In this mode a tick at zero reloads the counter from the reload value.
- R6: CONTROL bits 6 and 0 both clear select free-running mode. In this mode a tick at zero wraps the counted part of the counter to all ones.
- R7: CONTROL bit 0 set selects one-shot mode, which takes priority over bit 6. In this mode the counter holds at zero after reaching it, and only a LOAD write restarts it.
- R8: CONTROL bit 1 clear selects 16-bit mode. In this mode only VALUE bits 15:0 count, wrap and reload, while bits 31:16 keep the value from the last LOAD write.
- R9: CONTROL bits 3:2 select the prescale ratio: 00 divides by 1, 01 by 16, and 10 or 11 by 256. With division by N, the k-th decrement comes N·k+1 cycles after the enabling write edge.
- R10: A tick that takes the counted part from 1 to 0 sets the raw status. Any write to CLEAR clears it, unless a setting tick occurs in the same cycle, in which case setting wins.
- R11: The masked status and the timer's interrupt line both equal the raw status AND CONTROL bit 5. The combined line is the OR of all timer lines.
- R12: With CONTROL bit 7 set, the first decrement happens two cycles after the enabling write edge. Clearing bit 7 stops the counter from the edge after the write.
- R13: The timers are independent: accesses to one timer and its counting leave the other timer's registers and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all counting is on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase; a write takes effect when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_tmr | output | 2 | Per-timer interrupt lines (masked status) |
| irq_any | output | 1 | OR of all per-timer interrupt lines |

## Verification
The assertions assume the bus presents a write on exactly one cycle: psel, penable and pwrite are all high for a single clock per access. They also assume reset is held long enough for every register to settle. The bench drives each write as a setup cycle followed by one access cycle and then releases the bus. It reads only by presenting an address between clock edges, so a read never produces a write strobe.

// File: rtl/dt_pkg.sv
package dt_pkg;

    // Per-timer control byte, MSB first
    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] presc;
        logic       size32;
        logic       oneshot;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } cnt_state_e;

    typedef enum logic [2:0] {
        RG_LOAD   = 3'd0,
        RG_VALUE  = 3'd1,
        RG_CTRL   = 3'd2,
        RG_CLEAR  = 3'd3,
        RG_RAW    = 3'd4,
        RG_MASKED = 3'd5,
        RG_BGLOAD = 3'd6,
        RG_SPARE  = 3'd7
    } reg_idx_e;

    localparam int CTRL_W = 8;

endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
    parameter int PRE_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic             hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            2'd0:    hit = 1'b1;
            2'd1:    hit = &pre_q[FINE_W-1:0];
            default: hit = &pre_q;
        endcase
    end

    assign tick = run && !restart && hit;

endmodule

// File: rtl/dt_counter.sv
module dt_counter
    import dt_pkg::*;
#(
    parameter int W      = 32,
    parameter int PRE_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_bgload,
    input  logic              wr_ctrl,
    input  logic              wr_clr,
    input  logic [W-1:0]      wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [W-1:0]      load_o,
    output logic [W-1:0]      value_o,
    output logic              raw_o,
    output logic              irq_o
);

    localparam int H = W / 2;

    tmr_ctrl_t  ctrl_q;
    cnt_state_e state_q, state_d;
    logic [W-1:0] load_q, value_q, value_d;
    logic         raw_q, raw_d;
    logic         run, tick, at_one, at_zero, set_evt;
    logic [W-1:0] dec_v, wrap_v, reload_v;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_load || wr_bgload) load_q <= wdata;
        end
    end

    // ---------------- tick generation ----------------
    assign run = (state_q == ST_RUN) && ctrl_q.en;

    dt_prescaler #(.PRE_W(PRE_W), .FINE_W(FINE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_load),
        .sel     (ctrl_q.presc),
        .tick    (tick)
    );

    // ---------------- counted-part views ----------------
    always_comb begin
        if (ctrl_q.size32) begin
            at_one   = (value_q == W'(1));
            at_zero  = (value_q == '0);
            dec_v    = value_q - 1'b1;
            wrap_v   = '1;
            reload_v = load_q;
        end else begin
            at_one   = (value_q[H-1:0] == H'(1));
            at_zero  = (value_q[H-1:0] == '0);
            dec_v    = {value_q[W-1:H], value_q[H-1:0] - 1'b1};
            wrap_v   = {value_q[W-1:H], {H{1'b1}}};
            reload_v = {value_q[W-1:H], load_q[H-1:0]};
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_q.en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ctrl_q.en)
                    state_d = ST_IDLE;
                else if (tick && ctrl_q.oneshot && (at_one || at_zero))
                    state_d = ST_HALT;
            end
            ST_HALT: begin
                if (!ctrl_q.en)   state_d = ST_IDLE;
                else if (wr_load) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath outputs ----------------
    always_comb begin
        value_d = value_q;
        set_evt = 1'b0;
        if (wr_load) begin
            value_d = wdata;
        end else if (tick) begin
            if (at_zero) begin
                if (ctrl_q.oneshot)       value_d = value_q;
                else if (ctrl_q.periodic) value_d = reload_v;
                else                      value_d = wrap_v;
            end else begin
                value_d = dec_v;
                set_evt = at_one;
            end
        end
        if (set_evt)     raw_d = 1'b1;
        else if (wr_clr) raw_d = 1'b0;
        else             raw_d = raw_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '1;
            raw_q   <= 1'b0;
        end else begin
            value_q <= value_d;
            raw_q   <= raw_d;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign load_o  = load_q;
    assign value_o = value_q;
    assign raw_o   = raw_q;
    assign irq_o   = raw_q && ctrl_q.irq_en;

    // ---------------- assertions ----------------
    a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (value_q == $past(wdata)));

    a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wr_load) |=> $stable(value_q));

    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.size32 && !wr_load) |=> (value_q[W-1:H] == $past(value_q[W-1:H])));

    a_r10_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> (ctrl_q.size32 ? (value_q == '0) : (value_q[H-1:0] == '0)));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !tick) |=> !raw_q);

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !wr_load) |=> $stable(value_q));

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dt_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PRE_W   = 8,
    parameter int FINE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic [NUM_TMR-1:0] irq_tmr,
    output logic               irq_any
);

    localparam int MOD_LSB = 5;
    localparam int MOD_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
    localparam int TOP_LSB = MOD_LSB + MOD_W;

    logic              wr_en, in_range;
    logic [MOD_W-1:0]  mod_sel;
    reg_idx_e          idx;
    logic [DATA_W-1:0] rd_arr [NUM_TMR];

    assign wr_en    = psel && penable && pwrite;
    assign in_range = (paddr[ADDR_W-1:TOP_LSB] == '0) && (paddr[1:0] == 2'b00);
    assign mod_sel  = paddr[MOD_LSB +: MOD_W];
    assign idx      = reg_idx_e'(paddr[4:2]);

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        logic              hit;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] load_v, value_v;
        logic              raw, irq;

        assign hit = wr_en && in_range && (mod_sel == MOD_W'(gi));

        dt_counter #(.W(DATA_W), .PRE_W(PRE_W), .FINE_W(FINE_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_load   (hit && idx == RG_LOAD),
            .wr_bgload (hit && idx == RG_BGLOAD),
            .wr_ctrl   (hit && idx == RG_CTRL),
            .wr_clr    (hit && idx == RG_CLEAR),
            .wdata     (pwdata),
            .ctrl_o    (ctrl),
            .load_o    (load_v),
            .value_o   (value_v),
            .raw_o     (raw),
            .irq_o     (irq)
        );

        assign irq_tmr[gi] = irq;

        always_comb begin
            unique case (idx)
                RG_LOAD, RG_BGLOAD: rd_arr[gi] = load_v;
                RG_VALUE:           rd_arr[gi] = value_v;
                RG_CTRL:            rd_arr[gi] = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
                RG_RAW:             rd_arr[gi] = {{(DATA_W-1){1'b0}}, raw};
                RG_MASKED:          rd_arr[gi] = {{(DATA_W-1){1'b0}}, irq};
                default:            rd_arr[gi] = '0;
            endcase
        end
    end

    assign prdata  = in_range ? rd_arr[mod_sel] : '0;
    assign irq_any = |irq_tmr;

endmodule

// File: tb/dual_timer_tb.sv
`timescale 1ns/1ps
module dual_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  irq_tmr;
    logic        irq_any;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dual_timer u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_tmr(irq_tmr), .irq_any(irq_any)
    );

    localparam logic [7:0] O_LOAD = 8'h00, O_VAL = 8'h04, O_CTRL = 8'h08,
                           O_CLR = 8'h0C, O_RAW = 8'h10, O_MSK = 8'h14, O_BG = 8'h18;
    localparam logic [7:0] T1 = 8'h20;

    typedef struct packed {
        logic [15:0] tag;
        logic [7:0]  ctrl;
        logic [31:0] load;
        logic [15:0] waits;
        logic [31:0] exp_val;
        logic        exp_raw;
        logic        exp_msk;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R5", 8'h62, 32'd10,         16'd5,   32'd6,          1'b0, 1'b0},
        '{"R10",8'h62, 32'd3,          16'd4,   32'd0,          1'b1, 1'b1},
        '{"R5", 8'h62, 32'd3,          16'd5,   32'd3,          1'b1, 1'b1},
        '{"R5", 8'h62, 32'd3,          16'd7,   32'd1,          1'b1, 1'b1},
        '{"R6", 8'h22, 32'd2,          16'd5,   32'hFFFF_FFFE,  1'b1, 1'b1},
        '{"R8", 8'h20, 32'h0005_0001,  16'd4,   32'h0005_FFFE,  1'b1, 1'b1},
        '{"R7", 8'h23, 32'd2,          16'd8,   32'd0,          1'b1, 1'b1},
        '{"R8", 8'h60, 32'hABCD_0002,  16'd5,   32'hABCD_0001,  1'b1, 1'b1},
        '{"R9", 8'h66, 32'd100,        16'd17,  32'd99,         1'b0, 1'b0},
        '{"R9", 8'h66, 32'd100,        16'd33,  32'd98,         1'b0, 1'b0},
        '{"R9", 8'h6A, 32'd100,        16'd256, 32'd100,        1'b0, 1'b0},
        '{"R9", 8'h6A, 32'd100,        16'd257, 32'd99,         1'b0, 1'b0},
        '{"R11",8'h42, 32'd1,          16'd3,   32'd1,          1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        paddr = a;
        #1;
        d = prdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, v0, v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(O_LOAD, d);      chk("R1 load0", d, 32'd0);
        rd(O_VAL, d);       chk("R1 value0", d, 32'hFFFF_FFFF);
        rd(O_CTRL, d);      chk("R1 ctrl0", d, 32'd0);
        @(negedge clk);
        rd(T1 + O_RAW, d);  chk("R1 raw1", d, 32'd0);
        rd(T1 + O_VAL, d);  chk("R1 value1", d, 32'hFFFF_FFFF);
        chk("R1 irq", {29'd0, irq_any, irq_tmr}, 32'd0);

        // R2 read-only VALUE, out-of-range, CTRL readback
        wr(O_VAL, 32'h1234);
        rd(O_VAL, d);       chk("R2 value ro", d, 32'hFFFF_FFFF);
        wr(8'h40, 32'h77);
        rd(O_LOAD, d);      chk("R2 oor write", d, 32'd0);
        rd(8'h40, d);       chk("R2 oor read", d, 32'd0);
        wr(O_CTRL, 32'h5A);
        rd(O_CTRL, d);      chk("R2 ctrl rb", d, 32'h5A);
        rd(O_CLR, d);       chk("R2 clr reads0", d, 32'd0);

        // R3 LOAD sets counter at once (timer disabled: 0x5A has bit7 clear)
        wr(O_LOAD, 32'h55);
        rd(O_VAL, d);       chk("R3 value", d, 32'h55);

        // Vector table on timer 0
        for (int i = 0; i < NV; i++) begin
            wr(O_CTRL, {24'd0, VECS[i].ctrl});
            wr(O_CLR, 32'd0);
            wr(O_LOAD, VECS[i].load);
            wr(O_CTRL, {24'd0, VECS[i].ctrl | 8'h80});
            repeat (int'(VECS[i].waits)) @(negedge clk);
            rd(O_VAL, d); chk($sformatf("%s vec%0d value", VECS[i].tag, i), d, VECS[i].exp_val);
            rd(O_RAW, d); chk($sformatf("%s vec%0d raw", VECS[i].tag, i), d, {31'd0, VECS[i].exp_raw});
            rd(O_MSK, d); chk($sformatf("R11 vec%0d masked", i), d, {31'd0, VECS[i].exp_msk});
            chk($sformatf("R11 vec%0d irq0", i), {31'd0, irq_tmr[0]}, {31'd0, VECS[i].exp_msk});
        end

        // R10 clear after disable
        wr(O_CTRL, 32'h62);
        wr(O_CLR, 32'd0);
        rd(O_RAW, d);       chk("R10 cleared", d, 32'd0);
        rd(O_VAL, v0);

        // R4 background load on timer 1, R13 independence
        wr(T1 + O_CTRL, 32'h62);
        wr(T1 + O_CLR, 32'd0);
        wr(T1 + O_LOAD, 32'd4);
        wr(T1 + O_BG, 32'd2);
        rd(T1 + O_VAL, d);  chk("R4 value kept", d, 32'd4);
        rd(T1 + O_LOAD, d); chk("R4 reload", d, 32'd2);
        wr(T1 + O_CTRL, 32'hE2);
        repeat (6) @(negedge clk);
        rd(T1 + O_VAL, d);  chk("R4 reload used", d, 32'd2);
        rd(T1 + O_RAW, d);  chk("R10 raw1", d, 32'd1);
        rd(O_VAL, d);       chk("R13 timer0 still", d, v0);
        chk("R11 lines", {29'd0, irq_any, irq_tmr}, 32'b110);

        // R12 disable stops counting
        wr(T1 + O_CTRL, 32'h62);
        rd(T1 + O_VAL, v1);
        repeat (10) @(negedge clk);
        rd(T1 + O_VAL, d);  chk("R12 stopped", d, v1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule